// File: doc/BRIEF.md
# Direct Digital Synthesis Waveform Generator

This block turns a frequency request in hertz into a stream of 8-bit words for a parallel digital-to-analog converter. A 32-bit phase register advances by a tuning step on every clock; the step is the requested frequency times 159, which is close to 2^32 divided by a 27 MHz clock. The upper phase bits are then shaped into one of three periodic waves.

The sine wave is read from a folded quarter-period table, so only 64 seven-bit entries are stored. The square wave follows the top phase bit. The triangle is built from the next eight phase bits, mirrored in the second half of the period. The chosen wave is attenuated by a right shift of zero to three bits and registered, so one new converter word leaves the block on every clock. A synchronous reset clears the phase and the output word.

Top module: `dds_wavegen`

## Requirements
- R1: While `rst` is high at a clock edge, the phase and `dac_word` are cleared to zero at that edge. After `rst` falls, the first output word is the selected wave at phase zero.
- R2: On every clock edge without reset, the phase advances by `freq_hz` × 159, modulo 2^32.
- R3: With `wave_sel` = 0 (sine), the wave value for phase bits [31:24] = a lies within 2 of 127.5 + 127.5·sin(2π(a + 0.5)/256). Its peak is 255 (a = 63) and its trough is 0 (a = 191).
- R4: With `wave_sel` = 1 (square), the wave value is 0xFF when phase bit 31 is 1 and 0x00 when it is 0.
- R5: With `wave_sel` = 2 (triangle), the wave value is phase bits [30:23] when bit 31 is 0 and the bitwise complement of those bits when bit 31 is 1.
- R6: With `wave_sel` = 3, the output word is 0x00.
- R7: The output word is the wave value shifted right by `amp_shift` (0 to 3), giving full, half, quarter or eighth scale.
- R8: The output word registered at a clock edge is formed from the phase held before that edge, using the `wave_sel` and `amp_shift` present at that edge. A change of either input shows at the very next edge.
- R9: With `freq_hz` = 0, the phase holds and the output stays constant as long as the select and amplitude codes stay constant.
- R10: At the top request of 16,000,000 Hz, the phase wraps past 2^32 with no saturation, so the square wave keeps toggling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Generator clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_hz | input | 24 | Requested output frequency in hertz (0 to 16,000,000) |
| wave_sel | input | 2 | Wave choice: 0 sine, 1 square, 2 triangle, 3 silent |
| amp_shift | input | 2 | Attenuation as a right shift of 0 to 3 bits |
| dac_word | output | 8 | Converter word, one per clock |

## Verification
The phase register is the only long-lived state. A single wrong phase step changes every later output word, so the bench keeps its own phase mirror and compares every output word rather than sampling now and then. A wrong step shows as a wave value mismatch within one clock of the error. A fault in the sine fold or the triangle mirror appears only in the affected quarter or half of the period. For that reason one sweep steps the table address through all 256 values, and the triangle and square runs are long enough to cross both halves. An attenuation or select fault shows on the first word after the code changes, because the output register adds exactly one cycle.

// File: rtl/dds_pkg.sv
package dds_pkg;

   typedef enum logic [1:0] {
      WAVE_SINE   = 2'd0,
      WAVE_SQUARE = 2'd1,
      WAVE_TRI    = 2'd2,
      WAVE_OFF    = 2'd3
   } wave_e;

   // First quarter of a sine period sampled at half-step offsets, excess above mid-scale
   function automatic logic [6:0] quarter_sine(input logic [5:0] idx);
      logic [6:0] v;
      case (idx)
         6'd0:  v = 7'd2;    6'd1:  v = 7'd5;    6'd2:  v = 7'd8;    6'd3:  v = 7'd11;
         6'd4:  v = 7'd14;   6'd5:  v = 7'd17;   6'd6:  v = 7'd20;   6'd7:  v = 7'd23;
         6'd8:  v = 7'd26;   6'd9:  v = 7'd29;   6'd10: v = 7'd32;   6'd11: v = 7'd36;
         6'd12: v = 7'd39;   6'd13: v = 7'd41;   6'd14: v = 7'd44;   6'd15: v = 7'd47;
         6'd16: v = 7'd50;   6'd17: v = 7'd53;   6'd18: v = 7'd56;   6'd19: v = 7'd59;
         6'd20: v = 7'd61;   6'd21: v = 7'd64;   6'd22: v = 7'd67;   6'd23: v = 7'd70;
         6'd24: v = 7'd72;   6'd25: v = 7'd75;   6'd26: v = 7'd77;   6'd27: v = 7'd80;
         6'd28: v = 7'd82;   6'd29: v = 7'd84;   6'd30: v = 7'd87;   6'd31: v = 7'd89;
         6'd32: v = 7'd91;   6'd33: v = 7'd93;   6'd34: v = 7'd96;   6'd35: v = 7'd98;
         6'd36: v = 7'd100;  6'd37: v = 7'd101;  6'd38: v = 7'd103;  6'd39: v = 7'd105;
         6'd40: v = 7'd107;  6'd41: v = 7'd109;  6'd42: v = 7'd110;  6'd43: v = 7'd112;
         6'd44: v = 7'd113;  6'd45: v = 7'd115;  6'd46: v = 7'd116;  6'd47: v = 7'd117;
         6'd48: v = 7'd118;  6'd49: v = 7'd120;  6'd50: v = 7'd121;  6'd51: v = 7'd122;
         6'd52: v = 7'd122;  6'd53: v = 7'd123;  6'd54: v = 7'd124;  6'd55: v = 7'd125;
         6'd56: v = 7'd125;  6'd57: v = 7'd126;  6'd58: v = 7'd126;  6'd59: v = 7'd127;
         6'd60: v = 7'd127;  6'd61: v = 7'd127;  6'd62: v = 7'd127;  default: v = 7'd127;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int FREQ_W    = 24,
   parameter int PHASE_W   = 32,
   parameter int TUNE_MULT = 159
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [FREQ_W-1:0]  freq_hz,
   output logic [PHASE_W-1:0] step,
   output logic [PHASE_W-1:0] phase_q
);

   localparam int MULT_W = $clog2(TUNE_MULT + 1);
   localparam int PROD_W = FREQ_W + MULT_W;
   localparam logic [MULT_W-1:0] MULT_C = MULT_W'(TUNE_MULT);

   if (TUNE_MULT < 1) begin : g_bad_mult
      $error("dds_phase_acc: TUNE_MULT must be positive");
   end
   if (FREQ_W < 1 || PHASE_W < 2) begin : g_bad_width
      $error("dds_phase_acc: width parameters too small");
   end

   logic [PROD_W-1:0] prod;
   assign prod = PROD_W'(freq_hz) * PROD_W'(MULT_C);

   // Fit the product to the accumulator width
   if (PROD_W > PHASE_W) begin : g_trunc
      assign step = prod[PHASE_W-1:0];
   end else if (PROD_W < PHASE_W) begin : g_extend
      assign step = {{(PHASE_W-PROD_W){1'b0}}, prod};
   end else begin : g_exact
      assign step = prod;
   end

   always_ff @(posedge clk) begin
      if (rst) phase_q <= '0;
      else     phase_q <= phase_q + step;
   end

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
   parameter int ADDR_W = 8,
   parameter int DAC_W  = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DAC_W-1:0]  sine
);
   import dds_pkg::*;

   localparam int IDX_W = ADDR_W - 2;
   localparam logic [DAC_W-1:0] MID_HI = DAC_W'(1 << (DAC_W - 1));
   localparam logic [DAC_W-1:0] MID_LO = MID_HI - DAC_W'(1);

   if (ADDR_W != 8 || DAC_W != 8) begin : g_bad_geom
      $error("dds_sine_rom: table is built for 8 address and 8 data bits");
   end

   logic [1:0]       quad;
   logic [IDX_W-1:0] idx_raw;
   logic [IDX_W-1:0] idx_fold;
   logic [DAC_W-1:0] mag;

   assign quad     = addr[ADDR_W-1 -: 2];
   assign idx_raw  = addr[IDX_W-1:0];
   // Second and fourth quarters read the table backwards
   assign idx_fold = quad[0] ? ~idx_raw : idx_raw;
   assign mag      = DAC_W'(quarter_sine(idx_fold));
   // Second half of the period lies below mid-scale
   assign sine     = quad[1] ? (MID_LO - mag) : (MID_HI + mag);

endmodule

// File: rtl/dds_shaper.sv
module dds_shaper #(
   parameter int PHASE_W = 32,
   parameter int DAC_W   = 8,
   parameter int AMP_W   = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PHASE_W-1:0] phase,
   input  logic [1:0]         wave_sel,
   input  logic [AMP_W-1:0]   amp_shift,
   output logic [DAC_W-1:0]   dac_q
);
   import dds_pkg::*;

   localparam int MAX_SHIFT = (1 << AMP_W) - 1;

   if (PHASE_W < DAC_W + 1) begin : g_bad_phase
      $error("dds_shaper: phase must be wider than the output word");
   end
   if (MAX_SHIFT >= DAC_W) begin : g_bad_amp
      $error("dds_shaper: attenuation range exceeds the output word");
   end

   logic             msb;
   logic [DAC_W-1:0] sine_v;
   logic [DAC_W-1:0] square_v;
   logic [DAC_W-1:0] tri_bits;
   logic [DAC_W-1:0] tri_v;
   logic [DAC_W-1:0] wave_v;
   logic [DAC_W-1:0] stage [AMP_W+1];

   assign msb = phase[PHASE_W-1];

   dds_sine_rom #(.ADDR_W(DAC_W), .DAC_W(DAC_W)) u_rom (
      .addr (phase[PHASE_W-1 -: DAC_W]),
      .sine (sine_v)
   );

   assign square_v = {DAC_W{msb}};
   assign tri_bits = phase[PHASE_W-2 -: DAC_W];
   assign tri_v    = msb ? ~tri_bits : tri_bits;

   always_comb begin
      case (wave_e'(wave_sel))
         WAVE_SINE:   wave_v = sine_v;
         WAVE_SQUARE: wave_v = square_v;
         WAVE_TRI:    wave_v = tri_v;
         default:     wave_v = '0;
      endcase
   end

   // Logarithmic shifter, one stage per amplitude bit
   assign stage[0] = wave_v;
   for (genvar k = 0; k < AMP_W; k++) begin : g_shift
      assign stage[k+1] = amp_shift[k] ? (stage[k] >> (1 << k)) : stage[k];
   end

   always_ff @(posedge clk) begin
      if (rst) dac_q <= '0;
      else     dac_q <= stage[AMP_W];
   end

endmodule

// File: rtl/dds_wavegen.sv
module dds_wavegen #(
   parameter int FREQ_W    = 24,
   parameter int PHASE_W   = 32,
   parameter int DAC_W     = 8,
   parameter int AMP_W     = 2,
   parameter int TUNE_MULT = 159
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [FREQ_W-1:0] freq_hz,
   input  logic [1:0]        wave_sel,
   input  logic [AMP_W-1:0]  amp_shift,
   output logic [DAC_W-1:0]  dac_word
);

   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W-1:0] step;

   dds_phase_acc #(
      .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .TUNE_MULT(TUNE_MULT)
   ) u_acc (
      .clk     (clk),
      .rst     (rst),
      .freq_hz (freq_hz),
      .step    (step),
      .phase_q (phase_q)
   );

   dds_shaper #(
      .PHASE_W(PHASE_W), .DAC_W(DAC_W), .AMP_W(AMP_W)
   ) u_shape (
      .clk       (clk),
      .rst       (rst),
      .phase     (phase_q),
      .wave_sel  (wave_sel),
      .amp_shift (amp_shift),
      .dac_q     (dac_word)
   );

endmodule

// File: rtl/dds_wavegen_chk.sv
module dds_wavegen_chk #(
   parameter int FREQ_W    = 24,
   parameter int PHASE_W   = 32,
   parameter int DAC_W     = 8,
   parameter int AMP_W     = 2,
   parameter int TUNE_MULT = 159
) (
   input logic               clk,
   input logic               rst,
   input logic [FREQ_W-1:0]  freq_hz,
   input logic [1:0]         wave_sel,
   input logic [AMP_W-1:0]   amp_shift,
   input logic [DAC_W-1:0]   dac_word,
   input logic [PHASE_W-1:0] phase_q
);

   localparam logic [PHASE_W-1:0] MULT_P = PHASE_W'(TUNE_MULT);

   // R1: reset clears the output word at the next edge
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (dac_word == '0 && phase_q == '0));

   // R2: phase advances by the tuning step
   a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (phase_q - $past(phase_q)) == PHASE_W'($past(freq_hz)) * MULT_P);

   // R4: full-scale square is rail to rail only
   a_r4_square_rails: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wave_sel) == 2'd1 && $past(amp_shift) == '0)
      |-> (dac_word == '1 || dac_word == '0));

   // R6: unused select code is silent
   a_r6_off_silent: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wave_sel) == 2'd3) |-> dac_word == '0);

   // R7: attenuated word never exceeds the reduced full scale
   a_r7_amp_ceiling: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (32'(dac_word) >> (DAC_W - 32'($past(amp_shift)))) == 0);

   // R9: zero frequency freezes the output
   a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && $past(freq_hz, 2) == '0
       && $past(wave_sel) == $past(wave_sel, 2)
       && $past(amp_shift) == $past(amp_shift, 2))
      |-> $stable(dac_word));

endmodule

bind dds_wavegen dds_wavegen_chk #(
   .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .DAC_W(DAC_W),
   .AMP_W(AMP_W), .TUNE_MULT(TUNE_MULT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .freq_hz   (freq_hz),
   .wave_sel  (wave_sel),
   .amp_shift (amp_shift),
   .dac_word  (dac_word),
   .phase_q   (phase_q)
);

// File: tb/dds_wavegen_bench.sv
module dds_wavegen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;
   // {freq_hz[43:20], wave_sel[19:18], amp_shift[17:16], cycles[15:0]}
   localparam logic [43:0] VECS [NVEC] = '{
      {24'd1_000_000,  2'd1, 2'd0, 16'd60},
      {24'd1_000_000,  2'd2, 2'd0, 16'd60},
      {24'd2_000_000,  2'd0, 2'd0, 16'd60},
      {24'd3_333_333,  2'd0, 2'd1, 16'd40},
      {24'd16_000_000, 2'd1, 2'd0, 16'd40},
      {24'd16_000_000, 2'd2, 2'd2, 16'd40},
      {24'd500_000,    2'd2, 2'd3, 16'd40},
      {24'd7_000_000,  2'd0, 2'd3, 16'd40},
      {24'd123_457,    2'd1, 2'd1, 16'd40},
      {24'd5_000_000,  2'd3, 2'd0, 16'd10}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [23:0] freq_hz = '0;
   logic [1:0]  wave_sel = '0;
   logic [1:0]  amp_shift = '0;
   logic [7:0]  dac_word;

   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [31:0] ph_m = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dds_wavegen u_dds_wavegen (
      .clk(clk), .rst(rst), .freq_hz(freq_hz),
      .wave_sel(wave_sel), .amp_shift(amp_shift), .dac_word(dac_word)
   );

   task automatic check(input bit ok, input string req, input int got, input int lo, input int hi);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d..%0d", req, got, lo, hi);
      end
   endtask

   // Expected range of the output word for a given phase and codes
   task automatic expect_range(input logic [31:0] ph, input logic [1:0] sel,
                               input logic [1:0] amp, output int lo, output int hi);
      int  base;
      real s;
      case (sel)
         2'd0: begin
            s  = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * (real'(ph[31:24]) + 0.5) / 256.0);
            lo = int'($floor(s)) - 2;
            hi = int'($floor(s)) + 2;
            if (lo < 0) lo = 0;
            if (hi > 255) hi = 255;
         end
         2'd1: begin
            base = ph[31] ? 255 : 0;
            lo = base; hi = base;
         end
         2'd2: begin
            base = int'(ph[30:23]);
            if (ph[31]) base = 255 - base;
            lo = base; hi = base;
         end
         default: begin lo = 0; hi = 0; end
      endcase
      lo = lo >> amp;
      hi = hi >> amp;
   endtask

   // One clock: inputs stay stable over the edge, output sampled at the falling edge
   task automatic cycle(output int got, output int lo, output int hi);
      logic [31:0] ph_before;
      logic [1:0]  s, a;
      logic        r;
      logic [31:0] st;
      ph_before = ph_m;
      s = wave_sel; a = amp_shift; r = rst;
      st = 32'(freq_hz) * 32'd159;
      @(posedge clk);
      @(negedge clk);
      got = int'(dac_word);
      if (r) begin
         lo = 0; hi = 0; ph_m = '0;
      end else begin
         expect_range(ph_before, s, a, lo, hi);
         ph_m = ph_before + st;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got 0 expected 1 completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int got, lo, hi;
      int bad, first_got, first_lo, first_hi, mx, mn, rises;
      int prev_got;
      logic prev_sq;

      // R1: reset state, sine selected so a live wave would be near mid-scale
      @(negedge clk);
      freq_hz = 24'd1_000_000; wave_sel = 2'd0; amp_shift = 2'd0;
      for (int i = 0; i < 3; i++) cycle(got, lo, hi);
      check(got == 0, "R1 reset word", got, 0, 0);
      rst = 1'b0;

      // R1/R8: first word after release is the sine at phase zero
      cycle(got, lo, hi);
      check(got >= lo && got <= hi, "R1 first word after release", got, lo, hi);

      // Vector table: every word compared against the phase mirror (R2 R3 R4 R5 R6 R7)
      for (int v = 0; v < NVEC; v++) begin
         freq_hz   = VECS[v][43:20];
         wave_sel  = VECS[v][19:18];
         amp_shift = VECS[v][17:16];
         bad = 0; first_got = 0; first_lo = 0; first_hi = 0;
         for (int c = 0; c < int'(VECS[v][15:0]); c++) begin
            cycle(got, lo, hi);
            if (got < lo || got > hi) begin
               if (bad == 0) begin first_got = got; first_lo = lo; first_hi = hi; end
               bad++;
            end
         end
         case (VECS[v][19:18])
            2'd0:    check(bad == 0, $sformatf("R3 sine vector %0d (R2 R7)", v), first_got, first_lo, first_hi);
            2'd1:    check(bad == 0, $sformatf("R4 square vector %0d (R2 R7)", v), first_got, first_lo, first_hi);
            2'd2:    check(bad == 0, $sformatf("R5 triangle vector %0d (R2 R7)", v), first_got, first_lo, first_hi);
            default: check(bad == 0, $sformatf("R6 silent vector %0d", v), first_got, first_lo, first_hi);
         endcase
      end

      // R3: sweep every table address once, check shape and extremes
      freq_hz = 24'd105_521; wave_sel = 2'd0; amp_shift = 2'd0;
      bad = 0; mx = 0; mn = 255; first_got = 0; first_lo = 0; first_hi = 0;
      for (int c = 0; c < 260; c++) begin
         cycle(got, lo, hi);
         if (got > mx) mx = got;
         if (got < mn) mn = got;
         if (got < lo || got > hi) begin
            if (bad == 0) begin first_got = got; first_lo = lo; first_hi = hi; end
            bad++;
         end
      end
      check(bad == 0, "R3 sine sweep", first_got, first_lo, first_hi);
      check(mx == 255, "R3 sine peak", mx, 255, 255);
      check(mn == 0, "R3 sine trough", mn, 0, 0);

      // R9: zero frequency holds the phase and the word
      wave_sel = 2'd2; amp_shift = 2'd0; freq_hz = 24'd0;
      cycle(got, lo, hi);
      prev_got = got;
      bad = 0;
      for (int c = 0; c < 20; c++) begin
         cycle(got, lo, hi);
         if (got != prev_got || got < lo || got > hi) bad++;
      end
      check(bad == 0, "R9 frozen output", got, prev_got, prev_got);

      // R8: select change shows on the next word, phase still frozen
      wave_sel = 2'd1;
      cycle(got, lo, hi);
      check(got >= lo && got <= hi, "R8 select takes effect next edge", got, lo, hi);
      amp_shift = 2'd3; wave_sel = 2'd2;
      cycle(got, lo, hi);
      check(got >= lo && got <= hi, "R8 amplitude takes effect next edge", got, lo, hi);

      // R10: top frequency wraps the phase, square keeps toggling
      freq_hz = 24'd16_000_000; wave_sel = 2'd1; amp_shift = 2'd0;
      rises = 0; bad = 0;
      cycle(got, lo, hi);
      prev_sq = (got == 255);
      for (int c = 0; c < 100; c++) begin
         cycle(got, lo, hi);
         if (got < lo || got > hi) bad++;
         if (got == 255 && !prev_sq) rises++;
         prev_sq = (got == 255);
      end
      check(rises >= 5, "R10 square rises across wraps", rises, 5, 100);
      check(bad == 0, "R10 words after wrap", bad, 0, 0);

      // R1: mid-run reset clears, then restarts from phase zero
      wave_sel = 2'd1; amp_shift = 2'd0; freq_hz = 24'd9_000_000;
      for (int c = 0; c < 5; c++) cycle(got, lo, hi);
      rst = 1'b1;
      cycle(got, lo, hi);
      check(got == 0, "R1 mid-run reset word", got, 0, 0);
      rst = 1'b0;
      wave_sel = 2'd2;
      cycle(got, lo, hi);
      check(got == 0, "R1 triangle at phase zero after reset", got, 0, 0);
      cycle(got, lo, hi);
      check(got >= lo && got <= hi, "R1 phase restarts from zero (R2)", got, lo, hi);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule